// File: doc/BRIEF.md
# Dual-Port Address-Collision Arbiter

This block sits beside a memory with two independent ports, named left and right. Each port presents an active-low select, an address and an active-low write strobe. When both ports are selected on the same address, the arbiter gives the location to the port that was there first. It drives an active-low busy flag to the other port and gates that port's write strobe, so the memory never sees a write from the losing side. A tie in a single cycle goes to the left port by default. The decision uses only the selects and the addresses. Whether an access is a read or a write plays no part in it.

A mode input lets several arbiters serve one wide word. One arbiter runs as master and makes the decision. The others run in slave mode and each takes the master's busy flags on its busy inputs. In slave mode no decision is made: a low busy input blocks writes on that port and nothing else, and the busy outputs stay high. The busy outputs are registered, so a collision shows on them one clock after both ports are selected. The write gating acts in the same cycle.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: In master mode, when the two addresses differ or either select is high at a rising edge, both busy outputs are high after that edge.
- R2: When one port has held its select low on an address for at least one edge and the other port then selects the same address, the newcomer's busy output goes low after the edge where both are selected. The earlier port's busy output stays high.
- R3: When both ports first select the same address at the same edge, the left port wins by default (parameter TIE_LEFT=1). Right busy goes low and left busy stays high.
- R4: The two busy outputs are never low at the same time.
- R5: The decision does not depend on the write strobes. The same sequence of selects and addresses gives the same busy outputs with reads or with writes.
- R6: A gated write-enable output is high exactly when its port's select and write strobe are both low and that port is not inhibited. In master mode a port that has lost the location is inhibited, and the winner's write passes.
- R7: Ownership is held while the winner keeps its select and address. When the winner deselects or moves to another address, the loser's busy output returns high after the next edge.
- R8: In slave mode both busy outputs stay high and no decision is made. A port's busy input low inhibits that port's writes. A busy input high allows normal writes.
- R9: While reset is low, and after it, both busy outputs are high and no port owns the location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| slave_mode_i | input | 1 | 1 = slave mode (busy inputs gate writes), 0 = master mode |
| l_ce_ni | input | 1 | Left select, active low |
| l_addr_i | input | ADDR_W | Left address |
| l_we_ni | input | 1 | Left write strobe, active low |
| r_ce_ni | input | 1 | Right select, active low |
| r_addr_i | input | ADDR_W | Right address |
| r_we_ni | input | 1 | Right write strobe, active low |
| l_busy_in_ni | input | 1 | Left busy input from the master, used in slave mode |
| r_busy_in_ni | input | 1 | Right busy input from the master, used in slave mode |
| l_busy_no | output | 1 | Left busy, active low, registered |
| r_busy_no | output | 1 | Right busy, active low, registered |
| l_wr_inh_o | output | 1 | Left write inhibit, active high |
| r_wr_inh_o | output | 1 | Right write inhibit, active high |
| l_wr_en_o | output | 1 | Left gated write enable to the memory, active high |
| r_wr_en_o | output | 1 | Right gated write enable to the memory, active high |

## Verification
The properties assume that the port inputs change only between clock edges and hold steady across each rising edge. They also assume that mode changes are made only in such a settled cycle. The stimulus keeps to this: every input is driven on the falling edge, one step per clock. Each collision is set up from a known ownership state, either with both ports deselected or with a single port held on its address for at least one edge. Arrival order is therefore decided by the edge at which each select first appears.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int unsigned NUM_PORTS = 2;
   localparam int unsigned PORT_L    = 0;
   localparam int unsigned PORT_R    = 1;

endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ce_ni,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              settled_o
);
   logic              sel_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sel_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         sel_q  <= ~ce_ni;
         addr_q <= addr_i;
      end
   end

   // selected now and selected on the same address at the previous edge
   assign settled_o = ~ce_ni & sel_q & (addr_q == addr_i);

endmodule

// File: rtl/dpa_decide.sv
module dpa_decide
   import dpa_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic   slave_i,
   input  logic   match_i,
   input  logic   l_settled_i,
   input  logic   r_settled_i,
   input  owner_e owner_q_i,
   output owner_e owner_d_o
);
   owner_e tie_owner;

   generate
      if (TIE_LEFT) begin : g_tie_l
         assign tie_owner = OWN_LEFT;
      end else begin : g_tie_r
         assign tie_owner = OWN_RIGHT;
      end
   endgenerate

   always_comb begin
      if (slave_i || !match_i) begin
         owner_d_o = OWN_NONE;
      end else if (owner_q_i == OWN_LEFT && l_settled_i) begin
         owner_d_o = OWN_LEFT;
      end else if (owner_q_i == OWN_RIGHT && r_settled_i) begin
         owner_d_o = OWN_RIGHT;
      end else if (l_settled_i && !r_settled_i) begin
         owner_d_o = OWN_LEFT;
      end else if (r_settled_i && !l_settled_i) begin
         owner_d_o = OWN_RIGHT;
      end else begin
         owner_d_o = tie_owner;
      end
   end

endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate (
   input  logic slave_i,
   input  logic lost_i,
   input  logic busy_in_ni,
   input  logic ce_ni,
   input  logic we_ni,
   output logic inh_o,
   output logic wr_en_o
);
   always_comb begin
      if (slave_i) begin
         inh_o = ~busy_in_ni;
      end else begin
         inh_o = lost_i;
      end
      wr_en_o = ~ce_ni & ~we_ni & ~inh_o;
   end

endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter
   import dpa_pkg::*;
#(
   parameter int unsigned ADDR_W   = 10,
   parameter bit          TIE_LEFT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              slave_mode_i,
   input  logic              l_ce_ni,
   input  logic [ADDR_W-1:0] l_addr_i,
   input  logic              l_we_ni,
   input  logic              r_ce_ni,
   input  logic [ADDR_W-1:0] r_addr_i,
   input  logic              r_we_ni,
   input  logic              l_busy_in_ni,
   input  logic              r_busy_in_ni,
   output logic              l_busy_no,
   output logic              r_busy_no,
   output logic              l_wr_inh_o,
   output logic              r_wr_inh_o,
   output logic              l_wr_en_o,
   output logic              r_wr_en_o
);
   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("dpa_collision_arbiter: ADDR_W must be at least 1");
      end
   endgenerate

   logic              ce_n    [NUM_PORTS];
   logic              we_n    [NUM_PORTS];
   logic              bin_n   [NUM_PORTS];
   logic [ADDR_W-1:0] addr    [NUM_PORTS];
   logic              settled [NUM_PORTS];
   logic              lost    [NUM_PORTS];
   logic              inh     [NUM_PORTS];
   logic              wen     [NUM_PORTS];

   assign ce_n[PORT_L]  = l_ce_ni;
   assign ce_n[PORT_R]  = r_ce_ni;
   assign we_n[PORT_L]  = l_we_ni;
   assign we_n[PORT_R]  = r_we_ni;
   assign bin_n[PORT_L] = l_busy_in_ni;
   assign bin_n[PORT_R] = r_busy_in_ni;
   assign addr[PORT_L]  = l_addr_i;
   assign addr[PORT_R]  = r_addr_i;

   logic   match;
   owner_e owner_q;
   owner_e owner_d;

   assign match = ~l_ce_ni & ~r_ce_ni & (l_addr_i == r_addr_i);

   genvar p;
   generate
      for (p = 0; p < NUM_PORTS; p++) begin : g_port
         dpa_port_track #(.ADDR_W(ADDR_W)) track_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .ce_ni    (ce_n[p]),
            .addr_i   (addr[p]),
            .settled_o(settled[p])
         );

         dpa_write_gate gate_i (
            .slave_i   (slave_mode_i),
            .lost_i    (lost[p]),
            .busy_in_ni(bin_n[p]),
            .ce_ni     (ce_n[p]),
            .we_ni     (we_n[p]),
            .inh_o     (inh[p]),
            .wr_en_o   (wen[p])
         );
      end
   endgenerate

   dpa_decide #(.TIE_LEFT(TIE_LEFT)) decide_i (
      .slave_i    (slave_mode_i),
      .match_i    (match),
      .l_settled_i(settled[PORT_L]),
      .r_settled_i(settled[PORT_R]),
      .owner_q_i  (owner_q),
      .owner_d_o  (owner_d)
   );

   assign lost[PORT_L] = (owner_d == OWN_RIGHT);
   assign lost[PORT_R] = (owner_d == OWN_LEFT);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         owner_q <= OWN_NONE;
      end else begin
         owner_q <= owner_d;
      end
   end

   assign l_busy_no  = (owner_q != OWN_RIGHT);
   assign r_busy_no  = (owner_q != OWN_LEFT);
   assign l_wr_inh_o = inh[PORT_L];
   assign r_wr_inh_o = inh[PORT_R];
   assign l_wr_en_o  = wen[PORT_L];
   assign r_wr_en_o  = wen[PORT_R];

endmodule

// File: rtl/dpa_collision_arbiter_chk.sv
module dpa_collision_arbiter_chk #(
   parameter int unsigned ADDR_W = 10
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              slave_mode_i,
   input logic              l_ce_ni,
   input logic [ADDR_W-1:0] l_addr_i,
   input logic              l_we_ni,
   input logic              r_ce_ni,
   input logic [ADDR_W-1:0] r_addr_i,
   input logic              r_we_ni,
   input logic              l_busy_in_ni,
   input logic              r_busy_in_ni,
   input logic              l_busy_no,
   input logic              r_busy_no,
   input logic              l_wr_inh_o,
   input logic              r_wr_inh_o,
   input logic              l_wr_en_o,
   input logic              r_wr_en_o
);
   logic same_loc;
   assign same_loc = ~l_ce_ni & ~r_ce_ni & (l_addr_i == r_addr_i);

   // R1
   a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !same_loc |=> (l_busy_no && r_busy_no));

   // R4
   a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(!l_busy_no && !r_busy_no));

   // R6
   a_r6_loser_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!slave_mode_i && !l_busy_no && same_loc && $stable(r_ce_ni) && $stable(r_addr_i))
      |-> !l_wr_en_o);

   // R8
   a_r8_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slave_mode_i |=> (l_busy_no && r_busy_no));

   // R8
   a_r8_slave_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slave_mode_i && (!l_busy_in_ni || !r_busy_in_ni))
      |-> ((l_busy_in_ni || !l_wr_en_o) && (r_busy_in_ni || !r_wr_en_o)));

endmodule

bind dpa_collision_arbiter dpa_collision_arbiter_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .slave_mode_i(slave_mode_i),
   .l_ce_ni     (l_ce_ni),
   .l_addr_i    (l_addr_i),
   .l_we_ni     (l_we_ni),
   .r_ce_ni     (r_ce_ni),
   .r_addr_i    (r_addr_i),
   .r_we_ni     (r_we_ni),
   .l_busy_in_ni(l_busy_in_ni),
   .r_busy_in_ni(r_busy_in_ni),
   .l_busy_no   (l_busy_no),
   .r_busy_no   (r_busy_no),
   .l_wr_inh_o  (l_wr_inh_o),
   .r_wr_inh_o  (r_wr_inh_o),
   .l_wr_en_o   (l_wr_en_o),
   .r_wr_en_o   (r_wr_en_o)
);

// File: tb/dpa_collision_arbiter_tb.sv
module dpa_collision_arbiter_tb_top;
   localparam int unsigned AW = 10;
   localparam logic [AW-1:0] ADDR_A = 10'h155;
   localparam logic [AW-1:0] ADDR_B = 10'h2AA;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          slave = 1'b0;
   logic          l_ce_n = 1'b1, r_ce_n = 1'b1;
   logic          l_we_n = 1'b1, r_we_n = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic          l_bin_n = 1'b1, r_bin_n = 1'b1;
   logic          l_busy_n, r_busy_n, l_inh, r_inh, l_wen, r_wen;

   dpa_collision_arbiter #(.ADDR_W(AW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(slave),
      .l_ce_ni(l_ce_n), .l_addr_i(l_addr), .l_we_ni(l_we_n),
      .r_ce_ni(r_ce_n), .r_addr_i(r_addr), .r_we_ni(r_we_n),
      .l_busy_in_ni(l_bin_n), .r_busy_in_ni(r_bin_n),
      .l_busy_no(l_busy_n), .r_busy_no(r_busy_n),
      .l_wr_inh_o(l_inh), .r_wr_inh_o(r_inh),
      .l_wr_en_o(l_wen), .r_wr_en_o(r_wen)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;

   // expected {l_busy_n, r_busy_n, l_wen, r_wen} with a requirement tag
   logic [3:0] exp_q [$];
   string      tag_q [$];

   task automatic step(input logic sm, input logic lce, input logic [AW-1:0] la,
                       input logic lwe, input logic rce, input logic [AW-1:0] ra,
                       input logic rwe, input logic lbi, input logic rbi,
                       input logic [3:0] expv, input string tag);
      @(negedge clk);
      slave = sm; l_ce_n = lce; l_addr = la; l_we_n = lwe;
      r_ce_n = rce; r_addr = ra; r_we_n = rwe; l_bin_n = lbi; r_bin_n = rbi;
      exp_q.push_back(expv);
      tag_q.push_back(tag);
   endtask

   // monitor: compares one expected item one time unit after each edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [3:0] e;
         logic [3:0] a;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {l_busy_n, r_busy_n, l_wen, r_wen};
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s: {lbusy_n,rbusy_n,lwen,rwen} actual=%b expected=%b", t, a, e);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if ({l_busy_n, r_busy_n} !== 2'b11) begin
         errors++;
         $display("FAIL R9: busy during reset actual=%b expected=11", {l_busy_n, r_busy_n});
      end
      @(negedge clk);
      rst_n = 1'b1;
      //   sm  lce la      lwe rce ra      rwe lbi rbi  expected
      step(0, 0, ADDR_A, 0, 0, ADDR_B, 0, 1, 1, 4'b1111, "R1 diff addr");
      step(0, 0, ADDR_A, 0, 1, ADDR_A, 0, 1, 1, 4'b1110, "R1 right disabled");
      step(0, 0, ADDR_A, 1, 0, ADDR_A, 1, 1, 1, 4'b1000, "R2 right arrives later");
      step(0, 0, ADDR_A, 0, 0, ADDR_A, 0, 1, 1, 4'b1010, "R6 loser write blocked");
      step(0, 0, ADDR_B, 0, 0, ADDR_A, 0, 1, 1, 4'b1111, "R7 winner moves");
      step(0, 0, ADDR_A, 0, 0, ADDR_A, 0, 1, 1, 4'b0101, "R2 left arrives later");
      step(0, 0, ADDR_A, 0, 1, ADDR_A, 0, 1, 1, 4'b1110, "R7 winner deselects");
      step(0, 1, ADDR_A, 1, 1, ADDR_A, 1, 1, 1, 4'b1100, "R1 idle");
      step(0, 0, ADDR_A, 1, 0, ADDR_A, 1, 1, 1, 4'b1000, "R3 tie reads");
      step(0, 1, ADDR_A, 1, 1, ADDR_A, 1, 1, 1, 4'b1100, "R1 idle again");
      step(0, 0, ADDR_A, 0, 0, ADDR_A, 0, 1, 1, 4'b1010, "R5 tie writes");
      step(0, 0, ADDR_A, 0, 1, ADDR_A, 0, 1, 1, 4'b1110, "R7 loser leaves");
      step(1, 0, ADDR_A, 0, 0, ADDR_A, 0, 1, 1, 4'b1111, "R8 slave normal");
      step(1, 0, ADDR_A, 0, 0, ADDR_A, 0, 0, 1, 4'b1101, "R8 slave left inhibit");
      step(1, 0, ADDR_A, 0, 0, ADDR_A, 0, 1, 0, 4'b1110, "R8 slave right inhibit");
      step(0, 1, ADDR_A, 1, 1, ADDR_A, 1, 1, 1, 4'b1100, "R1 back to master idle");
      repeat (3) @(posedge clk);
      #2;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule